// File: doc/BRIEF.md
# Armed Baseline Window Current Monitor

The block supervises a stream of signed 24-bit current readings that arrive with a one-cycle valid strobe, roughly one every 10 µs. An operator request arms it: the next valid reading becomes the baseline, and two trip levels are derived from it by adding an upper margin and subtracting a lower margin. Every later valid reading is compared against that window directly, with no filtering or averaging in the path.

A reading strictly above the upper level or strictly below the lower level is a bad reading. When a programmable number of bad readings arrive back to back, the alarm trips and latches. The alarm output is fail-safe (high means good). It reads bad whenever the block is unarmed or in reset. It returns to good only through an explicit clear request, and that request takes effect only on an in-window reading. Status outputs report the arm state, the captured baseline, the running bad-reading count and which side caused the trip.

Top module: `cur_window_mon`

## Requirements
- R1: After reset, alarm_good_o is 0, armed_o is 0, bad_count_o is 0 and both side flags are 0.
- R2: A one-cycle arm_i pulse drops armed_o at the next edge. The first valid reading accepted at a later edge is stored in baseline_o, and armed_o rises at that same edge. While armed_o stays high, baseline_o does not change.
- R3: The upper level is baseline plus margin_hi_i and the lower level is baseline minus margin_lo_i. Both margins are 23-bit unsigned. A reading equal to a level is in window, and only a reading strictly beyond a level is bad.
- R4: Level arithmetic is done in 25-bit signed form and clamped to the signed 24-bit range (+8388607 / -8388608), so a large margin never wraps around.
- R5: Each bad valid reading raises bad_count_o by one, saturating at 15. An in-window valid reading sets it to 0. Cycles without sample_vld_i leave it unchanged.
- R6: The alarm trips at the edge that accepts the bad reading bringing bad_count_o up to trip_count_i, where a value of 0 is treated as 1. alarm_good_o is low right after that edge. Limits of 1, 2, 4 and 8 are supported.
- R7: Once tripped, alarm_good_o stays 0 through in-window readings until a clear is accepted.
- R8: A clear_i pulse is held pending until the next valid reading while armed. If that reading is in window, the trip is cleared at that edge. If it is bad, the request is discarded.
- R9: At the trip edge, trip_hi_o is set if the final reading was above the upper level, and trip_lo_o is set if it was below the lower level. At most one of the two is set. Both are cleared by an accepted clear or a new baseline capture.
- R10: While unarmed, readings are ignored: bad_count_o stays 0 and alarm_good_o stays 0.
- R11: Arming while already armed (tripped or not) recaptures the baseline from the next valid reading. The capture also zeroes the count and clears the trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_i | input | 24 | Signed current reading |
| sample_vld_i | input | 1 | Reading valid strobe |
| margin_hi_i | input | 23 | Unsigned margin above the baseline |
| margin_lo_i | input | 23 | Unsigned margin below the baseline |
| trip_count_i | input | 4 | Consecutive bad readings needed to trip (0 means 1) |
| arm_i | input | 1 | Arm / re-arm request pulse |
| clear_i | input | 1 | Alarm clear request pulse |
| alarm_good_o | output | 1 | Fail-safe alarm, 1 = good |
| armed_o | output | 1 | Baseline captured and monitoring |
| baseline_o | output | 24 | Captured baseline |
| bad_count_o | output | 4 | Current run of consecutive bad readings |
| trip_hi_o | output | 1 | Trip caused by the upper level |
| trip_lo_o | output | 1 | Trip caused by the lower level |

## Verification
The assertions watch these properties on every cycle:
- the count holds across idle cycles and is zero while unarmed;
- a latched alarm cannot recover without a valid reading;
- a trip only appears once the count has reached the programmed limit;
- the side flags are never both set;
- the baseline stays frozen while armed.

Only the bench's scenarios can show the rest, by stepping readings exactly onto and one step past each level:
- the window edges themselves;
- the clamping near full scale;
- that a clear is discarded when it meets a bad reading;
- the exact edge at which limits of 1, 2, 4, 8 and 0 trip.

// File: rtl/cwm_pkg.sv
package cwm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_LIVE = 2'd2
  } arm_state_e;

  typedef struct packed {
    logic hi;
    logic lo;
  } side_t;
endpackage

// File: rtl/cwm_window.sv
module cwm_window #(
  parameter int SAMPLE_W = 24
) (
  input  logic signed [SAMPLE_W-1:0] base_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic        [SAMPLE_W-2:0] margin_hi_i,
  input  logic        [SAMPLE_W-2:0] margin_lo_i,
  output logic                       above_o,
  output logic                       below_o
);
  localparam int XW = SAMPLE_W + 1;
  localparam logic signed [XW-1:0] TOP_X = {2'b00, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [XW-1:0] BOT_X = {2'b11, {(SAMPLE_W-1){1'b0}}};

  logic signed [XW-1:0] base_x, sum_hi, sum_lo;
  logic signed [SAMPLE_W-1:0] upper, lower;

  always_comb begin
    base_x = {base_i[SAMPLE_W-1], base_i};
    sum_hi = base_x + $signed({2'b00, margin_hi_i});
    sum_lo = base_x - $signed({2'b00, margin_lo_i});
    // clamp into the sample range so a large margin cannot wrap
    upper  = (sum_hi > TOP_X) ? TOP_X[SAMPLE_W-1:0] : sum_hi[SAMPLE_W-1:0];
    lower  = (sum_lo < BOT_X) ? BOT_X[SAMPLE_W-1:0] : sum_lo[SAMPLE_W-1:0];
  end

  assign above_o = sample_i > upper;
  assign below_o = sample_i < lower;
endmodule

// File: rtl/cwm_run_count.sv
module cwm_run_count #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             step_i,
  input  logic             bad_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             reach_o
);
  logic [CNT_W-1:0] cnt_q, cnt_inc, eff_lim;

  assign cnt_inc = (&cnt_q) ? cnt_q : cnt_q + CNT_W'(1);
  assign eff_lim = (limit_i == '0) ? CNT_W'(1) : limit_i;
  assign reach_o = step_i & bad_i & (cnt_inc >= eff_lim);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (flush_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= bad_i ? cnt_inc : '0;
  end
endmodule

// File: rtl/cur_window_mon.sv
module cur_window_mon
  import cwm_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic                       sample_vld_i,
  input  logic        [SAMPLE_W-2:0] margin_hi_i,
  input  logic        [SAMPLE_W-2:0] margin_lo_i,
  input  logic        [CNT_W-1:0]    trip_count_i,
  input  logic                       arm_i,
  input  logic                       clear_i,
  output logic                       alarm_good_o,
  output logic                       armed_o,
  output logic signed [SAMPLE_W-1:0] baseline_o,
  output logic        [CNT_W-1:0]    bad_count_o,
  output logic                       trip_hi_o,
  output logic                       trip_lo_o
);
  arm_state_e st_q;
  side_t      side_q;
  logic signed [SAMPLE_W-1:0] base_q;
  logic trip_q, clr_pend_q;
  logic capture, check, above, below, bad, reach;

  assign capture = (st_q == ST_WAIT) & sample_vld_i & ~arm_i;
  assign check   = (st_q == ST_LIVE) & sample_vld_i & ~arm_i;
  assign bad     = above | below;

  cwm_window #(.SAMPLE_W(SAMPLE_W)) u_window (
    .base_i      (base_q),
    .sample_i    (sample_i),
    .margin_hi_i (margin_hi_i),
    .margin_lo_i (margin_lo_i),
    .above_o     (above),
    .below_o     (below)
  );

  cwm_run_count #(.CNT_W(CNT_W)) u_count (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (arm_i | capture),
    .step_i  (check),
    .bad_i   (bad),
    .limit_i (trip_count_i),
    .cnt_o   (bad_count_o),
    .reach_o (reach)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      base_q <= '0;
    end else if (arm_i) begin
      st_q <= ST_WAIT;
    end else if (capture) begin
      st_q   <= ST_LIVE;
      base_q <= sample_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                clr_pend_q <= 1'b0;
    else if (clear_i)           clr_pend_q <= 1'b1;
    else if (capture || check)  clr_pend_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trip_q <= 1'b0;
      side_q <= '0;
    end else if (capture) begin
      trip_q <= 1'b0;
      side_q <= '0;
    end else if (check) begin
      if (reach) begin
        trip_q <= 1'b1;
        if (!trip_q) side_q <= '{hi: above, lo: below};
      end else if (!bad && clr_pend_q) begin
        trip_q <= 1'b0;
        side_q <= '0;
      end
    end
  end

  assign armed_o      = (st_q == ST_LIVE);
  assign alarm_good_o = armed_o & ~trip_q;
  assign baseline_o   = base_q;
  assign trip_hi_o    = side_q.hi;
  assign trip_lo_o    = side_q.lo;
endmodule

// File: rtl/cwm_chk.sv
module cwm_chk #(
  parameter int SAMPLE_W = 24,
  parameter int CNT_W    = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       sample_vld_i,
  input logic        [CNT_W-1:0]    trip_count_i,
  input logic                       arm_i,
  input logic                       alarm_good_o,
  input logic                       armed_o,
  input logic signed [SAMPLE_W-1:0] baseline_o,
  input logic        [CNT_W-1:0]    bad_count_o,
  input logic                       trip_hi_o,
  input logic                       trip_lo_o
);
  a_r5_idle_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sample_vld_i && !arm_i) |=> $stable(bad_count_o));

  a_r10_unarmed_count_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_o |-> (bad_count_o == '0));

  a_r7_alarm_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && !alarm_good_o && !sample_vld_i && !arm_i) |=> !alarm_good_o);

  a_r6_trip_needs_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && $fell(alarm_good_o)) |->
      (bad_count_o != '0 && bad_count_o >= $past(trip_count_i)));

  a_r9_side_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({trip_hi_o, trip_lo_o}));

  a_r9_side_means_bad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && (trip_hi_o || trip_lo_o)) |-> !alarm_good_o);

  a_r2_baseline_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o |=> (!armed_o || $stable(baseline_o)));
endmodule

bind cur_window_mon cwm_chk #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sample_vld_i (sample_vld_i),
  .trip_count_i (trip_count_i),
  .arm_i        (arm_i),
  .alarm_good_o (alarm_good_o),
  .armed_o      (armed_o),
  .baseline_o   (baseline_o),
  .bad_count_o  (bad_count_o),
  .trip_hi_o    (trip_hi_o),
  .trip_lo_o    (trip_lo_o)
);

// File: tb/cur_window_mon_tb_top.sv
module cur_window_mon_tb_top;
  localparam int W = 24;
  localparam int CW = 4;
  localparam longint MAXV = (longint'(1) <<< (W-1)) - 1;
  localparam longint MINV = -(longint'(1) <<< (W-1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [W-1:0] sample = '0;
  logic vld = 1'b0, arm = 1'b0, clr = 1'b0;
  logic [W-2:0] mhi = '0, mlo = '0;
  logic [CW-1:0] tcnt = CW'(1);
  logic alarm_good, armed, t_hi, t_lo;
  logic signed [W-1:0] baseline;
  logic [CW-1:0] bcnt;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit cmp_en = 1'b0, done = 1'b0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  cur_window_mon #(.SAMPLE_W(W), .CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .sample_vld_i(vld),
    .margin_hi_i(mhi), .margin_lo_i(mlo), .trip_count_i(tcnt),
    .arm_i(arm), .clear_i(clr), .alarm_good_o(alarm_good), .armed_o(armed),
    .baseline_o(baseline), .bad_count_o(bcnt), .trip_hi_o(t_hi), .trip_lo_o(t_lo)
  );

  // behavioural reference model
  int m_state = 0;  // 0 unarmed, 1 waiting for capture, 2 live
  longint m_base = 0;
  int m_cnt = 0;
  bit m_trip = 0, m_hi = 0, m_lo = 0, m_clrp = 0;

  function automatic longint clampv(longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_base = 0; m_cnt = 0;
      m_trip = 0; m_hi = 0; m_lo = 0; m_clrp = 0;
    end else begin
      longint s, up, lo;
      int lim;
      bit is_hi, is_lo;
      s  = longint'(sample);
      up = clampv(m_base + longint'(mhi));
      lo = clampv(m_base - longint'(mlo));
      lim = (tcnt == 0) ? 1 : int'(tcnt);
      is_hi = s > up;
      is_lo = s < lo;
      if (arm) begin
        m_state = 1; m_cnt = 0;
      end else if (m_state == 1 && vld) begin
        m_state = 2; m_base = s; m_cnt = 0;
        m_trip = 0; m_hi = 0; m_lo = 0; m_clrp = 0;
      end else if (m_state == 2 && vld) begin
        if (is_hi || is_lo) begin
          if (m_cnt < 15) m_cnt++;
          if (m_cnt >= lim) begin
            if (!m_trip) begin m_hi = is_hi; m_lo = is_lo; end
            m_trip = 1;
          end
        end else begin
          m_cnt = 0;
          if (m_clrp) begin m_trip = 0; m_hi = 0; m_lo = 0; end
        end
        m_clrp = 0;
      end
      if (clr) m_clrp = 1;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_en && !done) begin
      chk(cur_req, "alarm_good", longint'(alarm_good), longint'(m_state == 2 && !m_trip));
      chk(cur_req, "armed", longint'(armed), longint'(m_state == 2));
      chk(cur_req, "baseline", longint'(baseline), m_base);
      chk(cur_req, "bad_count", longint'(bcnt), longint'(m_cnt));
      chk(cur_req, "trip_hi", longint'(t_hi), longint'(m_hi));
      chk(cur_req, "trip_lo", longint'(t_lo), longint'(m_lo));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  task automatic put(input longint s);
    @(negedge clk); sample = W'(s); vld = 1'b1;
    @(negedge clk); vld = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    @(negedge clk);
    chk("R1", "reset alarm", longint'(alarm_good), 0);
    chk("R1", "reset armed", longint'(armed), 0);
    chk("R1", "reset count", longint'(bcnt), 0);

    cur_req = "R10";
    mhi = 23'd1000; mlo = 23'd500; tcnt = 4'd1;
    put(100000); put(-100000);
    chk("R10", "unarmed count", longint'(bcnt), 0);
    chk("R10", "unarmed alarm", longint'(alarm_good), 0);

    cur_req = "R2";
    do_arm();
    chk("R2", "armed before capture", longint'(armed), 0);
    put(5000);
    chk("R2", "baseline", longint'(baseline), 5000);
    chk("R2", "armed", longint'(armed), 1);
    chk("R2", "alarm good", longint'(alarm_good), 1);

    cur_req = "R3";
    put(6000);
    chk("R3", "at upper level", longint'(alarm_good), 1);
    put(4500);
    chk("R3", "at lower level", longint'(alarm_good), 1);
    put(6001);
    chk("R3", "beyond upper", longint'(alarm_good), 0);
    chk("R9", "hi side", longint'(t_hi), 1);
    chk("R9", "lo side", longint'(t_lo), 0);

    cur_req = "R7";
    put(5000); put(5100);
    chk("R7", "still latched", longint'(alarm_good), 0);

    cur_req = "R8";
    do_clear();
    put(4499);
    chk("R8", "clear on bad reading", longint'(alarm_good), 0);
    chk("R9", "side kept", longint'(t_hi), 1);
    put(5000);
    chk("R8", "clear was discarded", longint'(alarm_good), 0);
    do_clear();
    put(5000);
    chk("R8", "clear accepted", longint'(alarm_good), 1);
    chk("R9", "side cleared", longint'(t_hi), 0);

    cur_req = "R6";
    tcnt = 4'd4;
    for (int i = 0; i < 3; i++) put(7000);
    chk("R6", "3 of 4", longint'(alarm_good), 1);
    chk("R5", "count 3", longint'(bcnt), 3);
    put(5000);
    chk("R5", "good resets", longint'(bcnt), 0);
    for (int i = 0; i < 3; i++) put(3000);
    cur_req = "R5";
    idle(5);
    chk("R5", "idle holds", longint'(bcnt), 3);
    cur_req = "R6";
    put(3000);
    chk("R6", "4 of 4", longint'(alarm_good), 0);
    chk("R9", "lo side", longint'(t_lo), 1);
    do_clear(); put(5000);

    tcnt = 4'd8;
    for (int i = 0; i < 7; i++) put(9000);
    chk("R6", "7 of 8", longint'(alarm_good), 1);
    put(9000);
    chk("R6", "8 of 8", longint'(alarm_good), 0);
    cur_req = "R5";
    for (int i = 0; i < 10; i++) put(9000);
    chk("R5", "saturate", longint'(bcnt), 15);
    do_clear(); put(5000);

    cur_req = "R6";
    tcnt = 4'd2;
    put(1000);
    chk("R6", "1 of 2", longint'(alarm_good), 1);
    put(1000);
    chk("R6", "2 of 2", longint'(alarm_good), 0);
    do_clear(); put(5000);
    tcnt = 4'd0;
    put(1000);
    chk("R6", "limit 0 acts as 1", longint'(alarm_good), 0);

    cur_req = "R11";
    tcnt = 4'd1;
    do_arm();
    chk("R11", "rearm drops armed", longint'(armed), 0);
    chk("R11", "rearm count", longint'(bcnt), 0);
    put(7000);
    chk("R11", "new baseline", longint'(baseline), 7000);
    chk("R11", "alarm good", longint'(alarm_good), 1);

    cur_req = "R4";
    mhi = 23'h7FFFFF; mlo = 23'd100;
    do_arm(); put(8388000);
    put(8388607);
    chk("R4", "upper clamp", longint'(alarm_good), 1);
    put(8387899);
    chk("R4", "lower still active", longint'(alarm_good), 0);
    mhi = 23'd100; mlo = 23'h7FFFFF;
    do_arm(); put(-8388000);
    put(-8388608);
    chk("R4", "lower clamp", longint'(alarm_good), 1);
    put(-8387899);
    chk("R4", "upper still active", longint'(t_hi), 1);

    cur_req = "R5";
    mhi = 23'd600; mlo = 23'd400;
    do_arm(); put(1000);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      sample = W'(longint'(1000) + longint'($urandom_range(0, 2000)) - 1000);
      vld = ($urandom_range(0, 2) != 0);
      arm = ($urandom_range(0, 96) == 0);
      clr = ($urandom_range(0, 12) == 0);
      if ($urandom_range(0, 50) == 0) begin
        case ($urandom_range(0, 4))
          0: tcnt = 4'd0;
          1: tcnt = 4'd1;
          2: tcnt = 4'd2;
          3: tcnt = 4'd4;
          default: tcnt = 4'd8;
        endcase
      end
    end
    @(negedge clk); vld = 1'b0; arm = 1'b0; clr = 1'b0;
    idle(2);
    finish_run();
  end
endmodule